// File: doc/BRIEF.md
# Byte-Lane Write Strobe and Output Drive Control

This block sits between the pins of a synchronous flow-through memory and its storage array. It takes the chip-select inputs, the global write input, the byte-write gate and the per-lane byte-write inputs, and on each rising edge turns them into registered write strobes, one per nine-bit lane. On the same edge it registers the incoming data word together with its parity bits. The strobes and the registered word are valid together for the cycle after the edge, which is the cycle the array model performs the write.

The block also produces the enable for the tri-state data bus drivers. This enable comes from the registered select state, the registered strobes and an output-enable input that acts without waiting for the clock. A sleep input stops all internal registers so that they hold their values until sleep is released. The number of lanes is a parameter: four lanes give a 36-bit word and two lanes give an 18-bit word.

Top module: `bwoe_ctrl`

## Requirements
- R1: When the block is selected and `gw_n` is 0 at an active edge, every bit of `lane_we_o` is 1 in the following cycle, whatever `bwe_n` and `bw_n` are.
- R2: When the block is selected, `gw_n` is 1 and `bwe_n` is 0 at an active edge, `lane_we_o[k]` in the following cycle equals the inverse of `bw_n[k]` (active-low lane k request). When `gw_n` and `bwe_n` are both 1, `lane_we_o` is all zero in the following cycle, whatever `bw_n` is.
- R3: Lane k covers `data_i[8k+7:8k]` and parity bit `par_i[k]`. On a write edge the written lanes of `wr_data_o`/`wr_par_o` take the input values and the unwritten lanes keep their previous contents.
- R4: While any bit of `lane_we_o` is 1, `drive_en_o` is 0.
- R5: The block counts as selected at an edge only when `ce_n` is 0, `cs0` is 1 and `cs1_n` is 0. An edge that is not selected produces no write strobe and leaves the registered word unchanged.
- R6: `drive_en_o` follows `oe_n` without a clock edge: it is 1 only when `oe_n` is 0, the last active edge was selected and no strobe is active, and 0 as soon as `oe_n` is 1.
- R7: An edge sampled as not selected removes output drive from that edge on (single-cycle deselect); an edge sampled as selected with no write restores it.
- R8: Write strobes are single-cycle pulses: an active edge with no write request clears `lane_we_o`.
- R9: While `sleep_i` is 1, edges change no register: `lane_we_o`, `wr_data_o`, `wr_par_o` and the select state all hold.
- R10: A synchronous active-high `rst` clears the select state, all strobes and the registered word; after reset `drive_en_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sleep_i | input | 1 | Sleep: holds all registers while 1 |
| ce_n | input | 1 | Chip enable, active low |
| cs0 | input | 1 | Chip select, active high |
| cs1_n | input | 1 | Chip select, active low |
| gw_n | input | 1 | Global write, active low, writes every lane |
| bwe_n | input | 1 | Byte-write gate, active low |
| bw_n | input | LANES | Per-lane write requests, active low |
| oe_n | input | 1 | Output enable, active low, unclocked |
| data_i | input | 8*LANES | Write data bytes |
| par_i | input | LANES | Write parity bits, one per lane |
| lane_we_o | output | LANES | Registered per-lane write strobes |
| wr_data_o | output | 8*LANES | Registered write data |
| wr_par_o | output | LANES | Registered parity bits |
| drive_en_o | output | 1 | Data bus driver enable |

## Verification
The assertions watch on every cycle the write priority (global write filling all lanes, gated byte requests passing or being blocked), the capture of input data on a global write, output drive off while a strobe or `oe_n` is active, removal of drive after a deselected edge, and register hold during sleep. Only the bench scenarios show the lane-by-lane retention of unwritten bytes across a sequence of partial writes, the restoring of drive after an idle selected cycle, the immediate response of `drive_en_o` to `oe_n` between edges, and the values left after a reset in mid-operation.

// File: rtl/bwoe_pkg.sv
package bwoe_pkg;

    // bits of data per lane, parity bit excluded
    localparam int unsigned BYTE_BITS = 8;

    // kind of write decoded at an edge
    typedef enum logic [1:0] {
        WR_NONE   = 2'd0,
        WR_GLOBAL = 2'd1,
        WR_BYTES  = 2'd2
    } wr_kind_e;

endpackage

// File: rtl/bwoe_sel_dec.sv
module bwoe_sel_dec (
    input  logic ce_n,
    input  logic cs0,
    input  logic cs1_n,
    output logic sel
);

    // all three chip-select terms must agree
    always_comb begin
        sel = !ce_n && cs0 && !cs1_n;
    end

endmodule

// File: rtl/bwoe_wr_dec.sv
module bwoe_wr_dec #(
    parameter int unsigned LANES = 4
) (
    input  logic             sel,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bw_n,
    output logic [LANES-1:0] mask
);
    import bwoe_pkg::*;

    wr_kind_e kind;

    // priority: deselect, then global write, then gated byte writes
    always_comb begin
        if (!sel) begin
            kind = WR_NONE;
        end else if (!gw_n) begin
            kind = WR_GLOBAL;
        end else if (!bwe_n && (bw_n != {LANES{1'b1}})) begin
            kind = WR_BYTES;
        end else begin
            kind = WR_NONE;
        end
    end

    always_comb begin
        case (kind)
            WR_GLOBAL: mask = {LANES{1'b1}};
            WR_BYTES:  mask = ~bw_n;
            default:   mask = '0;
        endcase
    end

endmodule

// File: rtl/bwoe_drive.sv
module bwoe_drive #(
    parameter int unsigned LANES = 4
) (
    input  logic             oe_n,
    input  logic             sel_q,
    input  logic [LANES-1:0] we_q,
    output logic             drive_en
);

    // unclocked path from oe_n; any strobe forces the bus off
    always_comb begin
        drive_en = !oe_n && sel_q && !(|we_q);
    end

endmodule

// File: rtl/bwoe_ctrl.sv
module bwoe_ctrl #(
    parameter int unsigned LANES = 4
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  sleep_i,
    input  logic                                  ce_n,
    input  logic                                  cs0,
    input  logic                                  cs1_n,
    input  logic                                  gw_n,
    input  logic                                  bwe_n,
    input  logic [LANES-1:0]                      bw_n,
    input  logic                                  oe_n,
    input  logic [bwoe_pkg::BYTE_BITS*LANES-1:0]  data_i,
    input  logic [LANES-1:0]                      par_i,
    output logic [LANES-1:0]                      lane_we_o,
    output logic [bwoe_pkg::BYTE_BITS*LANES-1:0]  wr_data_o,
    output logic [LANES-1:0]                      wr_par_o,
    output logic                                  drive_en_o
);
    import bwoe_pkg::*;

    localparam int unsigned DATA_W = BYTE_BITS * LANES;

    typedef struct packed {
        logic              sel;
        logic [LANES-1:0]  we;
        logic [DATA_W-1:0] dat;
        logic [LANES-1:0]  par;
    } state_t;

    state_t st_d;
    state_t st_q;

    logic             sel_now;
    logic [LANES-1:0] mask_now;
    logic [DATA_W-1:0] dat_next;
    logic [LANES-1:0]  par_next;

    bwoe_sel_dec u_sel (
        .ce_n  (ce_n),
        .cs0   (cs0),
        .cs1_n (cs1_n),
        .sel   (sel_now)
    );

    bwoe_wr_dec #(.LANES(LANES)) u_wr (
        .sel   (sel_now),
        .gw_n  (gw_n),
        .bwe_n (bwe_n),
        .bw_n  (bw_n),
        .mask  (mask_now)
    );

    // per-lane capture: a lane loads only when its strobe is decoded
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        always_comb begin
            if (mask_now[k]) begin
                dat_next[k*BYTE_BITS +: BYTE_BITS] = data_i[k*BYTE_BITS +: BYTE_BITS];
                par_next[k]                        = par_i[k];
            end else begin
                dat_next[k*BYTE_BITS +: BYTE_BITS] = st_q.dat[k*BYTE_BITS +: BYTE_BITS];
                par_next[k]                        = st_q.par[k];
            end
        end
    end

    // next state; sleep acts as a gate on the internal clock
    always_comb begin
        st_d = st_q;
        if (!sleep_i) begin
            st_d.sel = sel_now;
            st_d.we  = mask_now;
            st_d.dat = dat_next;
            st_d.par = par_next;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    bwoe_drive #(.LANES(LANES)) u_drv (
        .oe_n     (oe_n),
        .sel_q    (st_q.sel),
        .we_q     (st_q.we),
        .drive_en (drive_en_o)
    );

    assign lane_we_o = st_q.we;
    assign wr_data_o = st_q.dat;
    assign wr_par_o  = st_q.par;

endmodule

// File: rtl/bwoe_ctrl_chk.sv
module bwoe_ctrl_chk #(
    parameter int unsigned LANES = 4
) (
    input logic                                 clk,
    input logic                                 rst,
    input logic                                 sleep_i,
    input logic                                 ce_n,
    input logic                                 cs0,
    input logic                                 cs1_n,
    input logic                                 gw_n,
    input logic                                 bwe_n,
    input logic [LANES-1:0]                     bw_n,
    input logic                                 oe_n,
    input logic [bwoe_pkg::BYTE_BITS*LANES-1:0] data_i,
    input logic [LANES-1:0]                     par_i,
    input logic [LANES-1:0]                     lane_we_o,
    input logic [bwoe_pkg::BYTE_BITS*LANES-1:0] wr_data_o,
    input logic [LANES-1:0]                     wr_par_o,
    input logic                                 drive_en_o
);

    logic picked;
    assign picked = !ce_n && cs0 && !cs1_n;

    assert_global_all_R1: assert property (@(posedge clk) disable iff (rst)
        (!sleep_i && picked && !gw_n) |=> (lane_we_o == {LANES{1'b1}}));

    assert_global_data_R3: assert property (@(posedge clk) disable iff (rst)
        (!sleep_i && picked && !gw_n) |=> (wr_data_o == $past(data_i) && wr_par_o == $past(par_i)));

    assert_bytes_pass_R2: assert property (@(posedge clk) disable iff (rst)
        (!sleep_i && picked && gw_n && !bwe_n) |=> (lane_we_o == ~$past(bw_n)));

    assert_bytes_blocked_R2: assert property (@(posedge clk) disable iff (rst)
        (!sleep_i && gw_n && bwe_n) |=> (lane_we_o == '0));

    assert_no_write_unsel_R5: assert property (@(posedge clk) disable iff (rst)
        (!sleep_i && !picked) |=> (lane_we_o == '0 && $stable(wr_data_o) && $stable(wr_par_o)));

    assert_write_kills_drive_R4: assert property (@(posedge clk) disable iff (rst)
        (|lane_we_o) |-> !drive_en_o);

    assert_oe_off_R6: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !drive_en_o);

    assert_deselect_R7: assert property (@(posedge clk) disable iff (rst)
        (!sleep_i && !picked) |=> !drive_en_o);

    assert_sleep_hold_R9: assert property (@(posedge clk) disable iff (rst)
        sleep_i |=> ($stable(lane_we_o) && $stable(wr_data_o) && $stable(wr_par_o)));

endmodule

bind bwoe_ctrl bwoe_ctrl_chk #(.LANES(LANES)) u_chk (.*);

// File: tb/bwoe_ctrl_tb.sv
module bwoe_ctrl_tb;

    localparam int L  = 4;
    localparam int DW = 8 * L;

    logic          clk = 1'b0;
    logic          rst;
    logic          sleep_i;
    logic          ce_n, cs0, cs1_n, gw_n, bwe_n, oe_n;
    logic [L-1:0]  bw_n;
    logic [DW-1:0] data_i;
    logic [L-1:0]  par_i;
    logic [L-1:0]  lane_we_o;
    logic [DW-1:0] wr_data_o;
    logic [L-1:0]  wr_par_o;
    logic          drive_en_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // expected state built from the requirements
    logic          e_sel;
    logic [L-1:0]  e_we;
    logic [DW-1:0] e_dat;
    logic [L-1:0]  e_par;

    always #5 clk = ~clk;

    bwoe_ctrl #(.LANES(L)) u_dut (
        .clk(clk), .rst(rst), .sleep_i(sleep_i),
        .ce_n(ce_n), .cs0(cs0), .cs1_n(cs1_n),
        .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n),
        .data_i(data_i), .par_i(par_i),
        .lane_we_o(lane_we_o), .wr_data_o(wr_data_o),
        .wr_par_o(wr_par_o), .drive_en_o(drive_en_o)
    );

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic e_drive();
        return !oe_n && e_sel && (e_we == '0);
    endfunction

    // one clock: drive at negedge, model the edge, settle after posedge
    task automatic step(input logic c_n, input logic c0, input logic c1_n,
                        input logic g_n, input logic b_n, input logic [L-1:0] bw,
                        input logic [DW-1:0] d, input logic [L-1:0] p, input logic slp);
        logic          s;
        logic [L-1:0]  m;
        @(negedge clk);
        ce_n = c_n; cs0 = c0; cs1_n = c1_n; gw_n = g_n; bwe_n = b_n;
        bw_n = bw; data_i = d; par_i = p; sleep_i = slp;
        @(posedge clk);
        s = !c_n && c0 && !c1_n;
        if (!s)        m = '0;
        else if (!g_n) m = '1;
        else if (!b_n) m = ~bw;
        else           m = '0;
        if (!slp) begin
            e_sel = s;
            e_we  = m;
            for (int k = 0; k < L; k++) begin
                if (m[k]) begin
                    e_dat[k*8 +: 8] = d[k*8 +: 8];
                    e_par[k]        = p[k];
                end
            end
        end
        #2;
    endtask

    task automatic idle_sel();
        step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, '1, '0, '0, 1'b0);
    endtask

    task automatic t_reset();
        rst = 1'b1; sleep_i = 0; ce_n = 1; cs0 = 0; cs1_n = 1; gw_n = 1; bwe_n = 1;
        bw_n = '1; oe_n = 0; data_i = '0; par_i = '0;
        e_sel = 0; e_we = '0; e_dat = '0; e_par = '0;
        repeat (3) @(posedge clk);
        #2;
        check(lane_we_o, '0, "R10 strobes after reset");
        check(wr_data_o, '0, "R10 data after reset");
        check(drive_en_o, 1'b0, "R10 drive after reset");
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_global();
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0101, 32'hA1B2C3D4, 4'b1011, 1'b0);
        check(lane_we_o, 4'hF, "R1 global write all lanes");
        check(wr_data_o, 32'hA1B2C3D4, "R3 global data captured");
        check(wr_par_o, 4'b1011, "R3 global parity captured");
        check(drive_en_o, 1'b0, "R4 drive off during write");
        idle_sel();
        check(lane_we_o, '0, "R8 strobe pulse ends");
        check(drive_en_o, 1'b1, "R7 drive restored after idle selected edge");
    endtask

    task automatic t_bytes();
        step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'b1010, 32'h11223344, 4'b0000, 1'b0);
        check(lane_we_o, 4'b0101, "R2 lane strobes follow bw_n");
        check(wr_data_o, e_dat, "R3 only lanes 0 and 2 load");
        check(wr_data_o, 32'hA122C344, "R3 lane byte positions");
        check(wr_par_o, 4'b1010, "R3 parity per lane");
        check(drive_en_o, 1'b0, "R4 byte write forces drive off");
        step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'b0111, 32'h55667788, 4'b1111, 1'b0);
        check(lane_we_o, 4'b1000, "R2 single upper lane");
        check(wr_data_o, 32'h5522C344, "R3 upper lane only");
        check(wr_par_o, 4'b1010, "R3 parity upper lane");
    endtask

    task automatic t_blocked();
        idle_sel();
        step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'b0000, 32'hDEADBEEF, 4'b0101, 1'b0);
        check(lane_we_o, '0, "R2 bwe_n high blocks bw_n");
        check(wr_data_o, 32'h5522C344, "R2 blocked write keeps data");
        check(drive_en_o, 1'b1, "R6 read drive with no write");
    endtask

    task automatic t_deselect();
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, '1, 32'h0BADF00D, 4'hF, 1'b0);
        check(lane_we_o, '0, "R5 ce_n high no write");
        check(drive_en_o, 1'b0, "R7 deselect drops drive next edge");
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, '1, 32'h0BADF00D, 4'hF, 1'b0);
        check(lane_we_o, '0, "R5 cs0 low no write");
        step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, '1, 32'h0BADF00D, 4'hF, 1'b0);
        check(lane_we_o, '0, "R5 cs1_n high no write");
        check(wr_data_o, 32'h5522C344, "R5 deselected data unchanged");
        check(drive_en_o, 1'b0, "R7 still deselected");
        idle_sel();
        check(drive_en_o, 1'b1, "R7 reselect restores drive");
    endtask

    task automatic t_oe();
        @(negedge clk);
        oe_n = 1'b1;
        #1;
        check(drive_en_o, 1'b0, "R6 oe_n high disables at once");
        oe_n = 1'b0;
        #1;
        check(drive_en_o, 1'b1, "R6 oe_n low enables at once");
    endtask

    task automatic t_sleep();
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, '1, 32'hCAFEF00D, 4'b0110, 1'b0);
        check(lane_we_o, 4'hF, "R1 write before sleep");
        step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, '1, '0, '0, 1'b1);
        check(lane_we_o, 4'hF, "R9 strobes hold in sleep");
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, '1, 32'h12345678, 4'b1001, 1'b1);
        check(wr_data_o, 32'hCAFEF00D, "R9 data holds in sleep");
        check(wr_par_o, 4'b0110, "R9 parity holds in sleep");
        idle_sel();
        check(lane_we_o, '0, "R9 wake resumes clocking");
        check(drive_en_o, e_drive(), "R6 drive after wake");
    endtask

    task automatic t_reset_mid();
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, '1, 32'h77777777, 4'hF, 1'b0);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #2;
        check(lane_we_o, '0, "R10 reset clears strobes");
        check(wr_data_o, '0, "R10 reset clears data");
        check(drive_en_o, 1'b0, "R10 reset clears select");
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        t_reset();
        t_global();
        t_bytes();
        t_blocked();
        t_deselect();
        t_oe();
        t_sleep();
        t_reset_mid();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule